// File: doc/BRIEF.md
# Instruction Decoder and Address Generator

This block takes one fixed-length 32-bit instruction word of a three-address load/store machine and decodes it in a single combinational pass. It cuts the word into a 6-bit opcode, two 5-bit register indices and a 16-bit field. In three-register forms the low five bits of that 16-bit field name a third register. It classifies the opcode and produces all the control a datapath needs for the current instruction: register-file read indices, write indices and enables, the ALU function with its second operand, memory read and write strobes, the branch kind and target, and trap and illegal-opcode flags.

The register-file values for the three named registers come in as inputs. The block forms the word address for every memory access mode: absolute, displacement, register-indexed, and the two stack modes. Push pre-increments its pointer register and pop post-decrements it. Push and pop each change two pieces of state, so they raise a split request that lets a sequencer spread them over two cycles. A separate pointer write port carries the pointer update. Memory, the register file and the ALU are outside the block.

Top module: `insn_decode_agu`

## Requirements
- R1: The register read indices are taken from fixed positions in the word: first index from bits [25:21], second index from bits [20:16], third index from bits [4:0]. The opcode is bits [31:26] and the 16-bit field is bits [15:0].
- R2: Opcode 1 reads memory at the zero-extended 16-bit field and writes the first register with source code 1 (memory). Opcode 3 writes memory at the same address with the first register's value as store data.
- R3: Opcodes 2 and 4 use the address sign-extended field plus the second register's value. Opcode 2 is a load into the first register and opcode 4 is a store of the first register.
- R4: Opcodes 48 and 49 use the address second register plus third register, over the full 32-bit width. Opcode 48 is a load into the first register and opcode 49 is a store of the first register.
- R5: Opcode 52 writes memory at first-register value plus one, with the second register's value as store data. It writes that same incremented value back to the first register through the pointer port and raises the split request.
- R6: Opcode 53 reads memory at the first register's value and writes the second register with source code 1. It writes first-register value minus one through the pointer port and raises the split request.
- R7: Opcodes 10 to 25 are valid ALU operations whose second operand is the sign-extended field. Their function code is the opcode minus 10, with codes in the order add, sub, mul, div, and, or, xor, eq, ne, lt, le, gt, ge, shl, shr, mod. The result goes to the first register with source code 0.
- R8: Opcodes 32 to 47 are valid ALU operations whose second operand is the third register's value. Their function code is the opcode minus 32, and the result goes to the first register with source code 0.
- R9: Control opcodes produce these branch codes: 6 gives 1 (jump), 7 gives 2 (jump and link), 8 gives 3 (jump if nonzero), 9 gives 4 (jump if zero) and 50 gives 5 (return). The target is the zero-extended field, except for return, whose target is the first register's value. Opcode 7 also writes the first register with source code 2 (link).
- R10: Opcodes 0 and 5 do nothing. Opcode 51 raises the trap flag. None of these three writes a register or touches memory.
- R11: Opcodes 26 to 31 and 54 to 63 raise the illegal flag. For these opcodes every register write, every memory strobe, the trap flag and the split request stay low.
- R12: A register or pointer write whose destination index is 0 has its enable forced low.
- R13: The memory read and memory write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| ra_val | input | DATA_W | Value of register at first index |
| rb_val | input | DATA_W | Value of register at second index |
| rc_val | input | DATA_W | Value of register at third index |
| ra_idx | output | 5 | First register index |
| rb_idx | output | 5 | Second register index |
| rc_idx | output | 5 | Third register index |
| alu_valid | output | 1 | Instruction is an ALU operation |
| alu_op | output | 4 | ALU function code |
| opb | output | DATA_W | Second ALU operand |
| wr_en | output | 1 | Data register write enable |
| wr_idx | output | 5 | Data register write index |
| wr_src | output | 2 | Write source: 0 ALU, 1 memory, 2 link |
| ptr_wr_en | output | 1 | Pointer register write enable |
| ptr_wr_idx | output | 5 | Pointer register write index |
| ptr_value | output | DATA_W | New pointer value |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Word address |
| store_data | output | DATA_W | Data to store |
| br_kind | output | 3 | Branch code |
| br_target | output | ADDR_W | Branch target |
| split_req | output | 1 | Needs two-cycle sequencing |
| trap | output | 1 | Trap instruction |
| illegal | output | 1 | Undefined opcode |

## Verification
The embedded assertions watch, on every evaluation, that the two memory strobes stay exclusive, that no enable survives with destination index zero, and that an illegal opcode leaves all writes, strobes and the trap and split flags low. They also check that the stack address lines up with the pointer update: the pushed word lands at the new pointer, and the popped word comes from one above it. Only the bench's sweep can show the rest. That covers the right field sign- or zero-extension per mode, address sums that wrap at 32 bits, the ALU code offsets for both operand forms, the branch codes and targets, and which register each opcode writes with which source.

// File: rtl/idagu_pkg.sv
package idagu_pkg;
   localparam int INSN_W = 32;
   localparam int OPC_W  = 6;
   localparam int RIDX_W = 5;
   localparam int DISP_W = 16;

   typedef enum logic [3:0] {
      ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV,
      ALU_AND, ALU_OR,  ALU_XOR, ALU_EQ,
      ALU_NE,  ALU_LT,  ALU_LE,  ALU_GT,
      ALU_GE,  ALU_SHL, ALU_SHR, ALU_MOD
   } alu_op_e;

   typedef enum logic [2:0] {
      BR_NONE, BR_JMP, BR_JAL, BR_JT, BR_JF, BR_RET
   } br_e;

   typedef enum logic [1:0] {
      WS_ALU, WS_MEM, WS_LINK
   } wsrc_e;

   typedef enum logic [2:0] {
      AM_NONE, AM_ABS, AM_DISP, AM_INDEX, AM_PUSH, AM_POP
   } amode_e;

   localparam logic [OPC_W-1:0] OPC_NOP_A     = 6'd0;
   localparam logic [OPC_W-1:0] OPC_LD_ABS    = 6'd1;
   localparam logic [OPC_W-1:0] OPC_LD_DISP   = 6'd2;
   localparam logic [OPC_W-1:0] OPC_ST_ABS    = 6'd3;
   localparam logic [OPC_W-1:0] OPC_ST_DISP   = 6'd4;
   localparam logic [OPC_W-1:0] OPC_NOP_B     = 6'd5;
   localparam logic [OPC_W-1:0] OPC_JMP       = 6'd6;
   localparam logic [OPC_W-1:0] OPC_JAL       = 6'd7;
   localparam logic [OPC_W-1:0] OPC_JT        = 6'd8;
   localparam logic [OPC_W-1:0] OPC_JF        = 6'd9;
   localparam logic [OPC_W-1:0] OPC_IMM_LO    = 6'd10;
   localparam logic [OPC_W-1:0] OPC_IMM_HI    = 6'd25;
   localparam logic [OPC_W-1:0] OPC_REG_LO    = 6'd32;
   localparam logic [OPC_W-1:0] OPC_REG_HI    = 6'd47;
   localparam logic [OPC_W-1:0] OPC_LD_IDX    = 6'd48;
   localparam logic [OPC_W-1:0] OPC_ST_IDX    = 6'd49;
   localparam logic [OPC_W-1:0] OPC_RET       = 6'd50;
   localparam logic [OPC_W-1:0] OPC_TRAP      = 6'd51;
   localparam logic [OPC_W-1:0] OPC_PUSH      = 6'd52;
   localparam logic [OPC_W-1:0] OPC_POP       = 6'd53;

   typedef struct packed {
      logic    legal;
      logic    alu_valid;
      logic    alu_imm;
      alu_op_e alu_op;
      br_e     br;
      logic    br_reg;
      logic    wr_req;
      logic    wr_to_b;
      wsrc_e   wsrc;
      logic    ptr_req;
      logic    mem_rd;
      logic    mem_wr;
      amode_e  amode;
      logic    store_b;
      logic    trap;
      logic    split;
   } ctrl_t;
endpackage

// File: rtl/idagu_fields.sv
module idagu_fields
   import idagu_pkg::*;
#(
   parameter int IW  = INSN_W,
   parameter int OW  = OPC_W,
   parameter int RW  = RIDX_W,
   parameter int FW  = DISP_W
) (
   input  logic [IW-1:0] insn,
   output logic [OW-1:0] opc,
   output logic [RW-1:0] fa,
   output logic [RW-1:0] fb,
   output logic [RW-1:0] fc,
   output logic [FW-1:0] disp
);
   localparam int OP_LSB = IW - OW;
   localparam int A_LSB  = OP_LSB - RW;
   localparam int B_LSB  = A_LSB - RW;

   generate
      if (B_LSB != FW) begin : g_layout_bad
         $error("idagu_fields: field widths do not fill the word");
      end
      if (RW > FW) begin : g_ridx_bad
         $error("idagu_fields: third index wider than the field");
      end
   endgenerate

   assign opc  = insn[IW-1:OP_LSB];
   assign fa   = insn[OP_LSB-1:A_LSB];
   assign fb   = insn[A_LSB-1:B_LSB];
   assign disp = insn[FW-1:0];
   assign fc   = disp[RW-1:0];
endmodule

// File: rtl/idagu_classify.sv
module idagu_classify
   import idagu_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output ctrl_t            ctl
);
   always_comb begin
      ctl        = '0;
      ctl.alu_op = ALU_ADD;
      ctl.br     = BR_NONE;
      ctl.wsrc   = WS_ALU;
      ctl.amode  = AM_NONE;
      case (opc) inside
         OPC_NOP_A, OPC_NOP_B: begin
            ctl.legal = 1'b1;
         end
         OPC_LD_ABS: begin
            ctl.legal  = 1'b1;
            ctl.wr_req = 1'b1;
            ctl.wsrc   = WS_MEM;
            ctl.mem_rd = 1'b1;
            ctl.amode  = AM_ABS;
         end
         OPC_LD_DISP: begin
            ctl.legal  = 1'b1;
            ctl.wr_req = 1'b1;
            ctl.wsrc   = WS_MEM;
            ctl.mem_rd = 1'b1;
            ctl.amode  = AM_DISP;
         end
         OPC_ST_ABS: begin
            ctl.legal  = 1'b1;
            ctl.mem_wr = 1'b1;
            ctl.amode  = AM_ABS;
         end
         OPC_ST_DISP: begin
            ctl.legal  = 1'b1;
            ctl.mem_wr = 1'b1;
            ctl.amode  = AM_DISP;
         end
         OPC_JMP: begin
            ctl.legal = 1'b1;
            ctl.br    = BR_JMP;
         end
         OPC_JAL: begin
            ctl.legal  = 1'b1;
            ctl.br     = BR_JAL;
            ctl.wr_req = 1'b1;
            ctl.wsrc   = WS_LINK;
         end
         OPC_JT: begin
            ctl.legal = 1'b1;
            ctl.br    = BR_JT;
         end
         OPC_JF: begin
            ctl.legal = 1'b1;
            ctl.br    = BR_JF;
         end
         [OPC_IMM_LO:OPC_IMM_HI]: begin
            ctl.legal     = 1'b1;
            ctl.alu_valid = 1'b1;
            ctl.alu_imm   = 1'b1;
            ctl.alu_op    = alu_op_e'(4'(opc - OPC_IMM_LO));
            ctl.wr_req    = 1'b1;
         end
         [OPC_REG_LO:OPC_REG_HI]: begin
            ctl.legal     = 1'b1;
            ctl.alu_valid = 1'b1;
            ctl.alu_op    = alu_op_e'(4'(opc - OPC_REG_LO));
            ctl.wr_req    = 1'b1;
         end
         OPC_LD_IDX: begin
            ctl.legal  = 1'b1;
            ctl.wr_req = 1'b1;
            ctl.wsrc   = WS_MEM;
            ctl.mem_rd = 1'b1;
            ctl.amode  = AM_INDEX;
         end
         OPC_ST_IDX: begin
            ctl.legal  = 1'b1;
            ctl.mem_wr = 1'b1;
            ctl.amode  = AM_INDEX;
         end
         OPC_RET: begin
            ctl.legal  = 1'b1;
            ctl.br     = BR_RET;
            ctl.br_reg = 1'b1;
         end
         OPC_TRAP: begin
            ctl.legal = 1'b1;
            ctl.trap  = 1'b1;
         end
         OPC_PUSH: begin
            ctl.legal   = 1'b1;
            ctl.ptr_req = 1'b1;
            ctl.mem_wr  = 1'b1;
            ctl.amode   = AM_PUSH;
            ctl.store_b = 1'b1;
            ctl.split   = 1'b1;
         end
         OPC_POP: begin
            ctl.legal   = 1'b1;
            ctl.ptr_req = 1'b1;
            ctl.wr_req  = 1'b1;
            ctl.wr_to_b = 1'b1;
            ctl.wsrc    = WS_MEM;
            ctl.mem_rd  = 1'b1;
            ctl.amode   = AM_POP;
            ctl.split   = 1'b1;
         end
         default: begin
            ctl.legal = 1'b0;
         end
      endcase
   end

   always_comb begin
      AST_STROBE_EXCL_CLS: assert (!(ctl.mem_rd && ctl.mem_wr)) else $error("class sets both strobes"); // R13
      AST_SPLIT_IS_STACK: assert (!ctl.split || (ctl.amode == AM_PUSH) || (ctl.amode == AM_POP)) else $error("split outside stack op"); // R5
   end
endmodule

// File: rtl/idagu_opsel.sv
module idagu_opsel
   import idagu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DISP_W-1:0] disp,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] rc_val,
   output logic [DATA_W-1:0] imm_sx,
   output logic [DATA_W-1:0] opb
);
   localparam int EXT_W = DATA_W - DISP_W;

   generate
      if (EXT_W > 0) begin : g_sext
         assign imm_sx = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else if (EXT_W == 0) begin : g_same
         assign imm_sx = disp;
      end else begin : g_narrow
         $error("idagu_opsel: DATA_W below field width");
      end
   endgenerate

   assign opb = use_imm ? imm_sx : rc_val;
endmodule

// File: rtl/idagu_agu.sv
module idagu_agu
   import idagu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  amode_e            amode,
   input  logic [DISP_W-1:0] disp,
   input  logic [DATA_W-1:0] imm_sx,
   input  logic [DATA_W-1:0] ra_val,
   input  logic [DATA_W-1:0] rb_val,
   input  logic [DATA_W-1:0] rc_val,
   input  logic              store_b,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] ptr_value,
   output logic [DATA_W-1:0] store_data
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] ea_abs, ea_disp, ea_idx, sp_inc, sp_dec, ea_full;

   generate
      if (ADDR_W > DATA_W) begin : g_addr_bad
         $error("idagu_agu: ADDR_W wider than DATA_W");
      end
   endgenerate

   assign ea_abs  = DATA_W'(disp);
   assign ea_disp = imm_sx + rb_val;
   assign ea_idx  = rb_val + rc_val;
   assign sp_inc  = ra_val + ONE;
   assign sp_dec  = ra_val - ONE;

   always_comb begin
      case (amode)
         AM_ABS:   ea_full = ea_abs;
         AM_DISP:  ea_full = ea_disp;
         AM_INDEX: ea_full = ea_idx;
         AM_PUSH:  ea_full = sp_inc;
         AM_POP:   ea_full = ra_val;
         default:  ea_full = '0;
      endcase
   end

   assign ptr_value  = (amode == AM_POP) ? sp_dec : sp_inc;
   assign store_data = store_b ? rb_val : ra_val;

   generate
      if (ADDR_W == DATA_W) begin : g_addr_full
         assign mem_addr = ea_full;
      end else begin : g_addr_trunc
         assign mem_addr = ea_full[ADDR_W-1:0];
      end
   endgenerate

   always_comb begin
      AST_PUSH_AT_NEW_PTR: assert ((amode != AM_PUSH) || (ea_full == ptr_value)) else $error("push address off pointer"); // R5
      AST_POP_AT_OLD_PTR: assert ((amode != AM_POP) || ((ptr_value + ONE) == ea_full)) else $error("pop address off pointer"); // R6
   end
endmodule

// File: rtl/insn_decode_agu.sv
module insn_decode_agu
   import idagu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic [INSN_W-1:0] instr,
   input  logic [DATA_W-1:0] ra_val,
   input  logic [DATA_W-1:0] rb_val,
   input  logic [DATA_W-1:0] rc_val,
   output logic [RIDX_W-1:0] ra_idx,
   output logic [RIDX_W-1:0] rb_idx,
   output logic [RIDX_W-1:0] rc_idx,
   output logic              alu_valid,
   output logic [3:0]        alu_op,
   output logic [DATA_W-1:0] opb,
   output logic              wr_en,
   output logic [RIDX_W-1:0] wr_idx,
   output logic [1:0]        wr_src,
   output logic              ptr_wr_en,
   output logic [RIDX_W-1:0] ptr_wr_idx,
   output logic [DATA_W-1:0] ptr_value,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] store_data,
   output logic [2:0]        br_kind,
   output logic [ADDR_W-1:0] br_target,
   output logic              split_req,
   output logic              trap,
   output logic              illegal
);
   logic [OPC_W-1:0]  opc;
   logic [DISP_W-1:0] disp;
   logic [DATA_W-1:0] imm_sx;
   ctrl_t             ctl;

   idagu_fields u_fields (
      .insn (instr),
      .opc  (opc),
      .fa   (ra_idx),
      .fb   (rb_idx),
      .fc   (rc_idx),
      .disp (disp)
   );

   idagu_classify u_cls (
      .opc (opc),
      .ctl (ctl)
   );

   idagu_opsel #(.DATA_W(DATA_W)) u_opsel (
      .disp    (disp),
      .use_imm (ctl.alu_imm),
      .rc_val  (rc_val),
      .imm_sx  (imm_sx),
      .opb     (opb)
   );

   idagu_agu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agu (
      .amode      (ctl.amode),
      .disp       (disp),
      .imm_sx     (imm_sx),
      .ra_val     (ra_val),
      .rb_val     (rb_val),
      .rc_val     (rc_val),
      .store_b    (ctl.store_b),
      .mem_addr   (mem_addr),
      .ptr_value  (ptr_value),
      .store_data (store_data)
   );

   assign alu_valid  = ctl.alu_valid;
   assign alu_op     = ctl.alu_op;
   assign wr_idx     = ctl.wr_to_b ? rb_idx : ra_idx;
   assign wr_en      = ctl.wr_req && (wr_idx != '0);
   assign wr_src     = ctl.wsrc;
   assign ptr_wr_idx = ra_idx;
   assign ptr_wr_en  = ctl.ptr_req && (ra_idx != '0);
   assign mem_rd     = ctl.mem_rd;
   assign mem_wr     = ctl.mem_wr;
   assign br_kind    = ctl.br;
   assign br_target  = ctl.br_reg ? ra_val[ADDR_W-1:0] : ADDR_W'(disp);
   assign split_req  = ctl.split;
   assign trap       = ctl.trap;
   assign illegal    = !ctl.legal;

   always_comb begin
      AST_STROBE_EXCL: assert (!(mem_rd && mem_wr)) else $error("both strobes high"); // R13
      AST_ZERO_DEST_WR: assert (!(wr_en && (wr_idx == '0))) else $error("write to index 0"); // R12
      AST_ZERO_DEST_PTR: assert (!(ptr_wr_en && (ptr_wr_idx == '0))) else $error("pointer write to index 0"); // R12
      AST_ILLEGAL_QUIET: assert (!illegal || !(wr_en || ptr_wr_en || mem_rd || mem_wr || trap || split_req)) else $error("illegal opcode has effect"); // R11
   end
endmodule

// File: tb/insn_decode_agu_bench.sv
module insn_decode_agu_bench;
   localparam int DW = 32;
   localparam int AW = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [31:0]   instr = '0;
   logic [DW-1:0] ra_val = '0, rb_val = '0, rc_val = '0;
   logic [4:0]    ra_idx, rb_idx, rc_idx, wr_idx, ptr_wr_idx;
   logic          alu_valid, wr_en, ptr_wr_en, mem_rd, mem_wr, split_req, trap, illegal;
   logic [3:0]    alu_op;
   logic [DW-1:0] opb, ptr_value, store_data;
   logic [1:0]    wr_src;
   logic [AW-1:0] mem_addr, br_target;
   logic [2:0]    br_kind;

   int  total = 0;
   int  bad   = 0;
   logic done = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   insn_decode_agu #(.DATA_W(DW), .ADDR_W(AW)) u_insn_decode_agu (
      .instr(instr), .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val),
      .ra_idx(ra_idx), .rb_idx(rb_idx), .rc_idx(rc_idx),
      .alu_valid(alu_valid), .alu_op(alu_op), .opb(opb),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_src(wr_src),
      .ptr_wr_en(ptr_wr_en), .ptr_wr_idx(ptr_wr_idx), .ptr_value(ptr_value),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .store_data(store_data),
      .br_kind(br_kind), .br_target(br_target),
      .split_req(split_req), .trap(trap), .illegal(illegal)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s op=%0d actual=%h expected=%h", req, what, instr[31:26], act, exp);
      end
   endtask

   function automatic logic [31:0] nextrnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   task automatic run_vec(input int op, input int a, input int b, input logic [15:0] d);
      logic [31:0] sx, zx;
      logic        e_ill, e_trap, e_imm, e_reg, e_wr, e_ptr, e_rd, e_wrm, e_split;
      logic [4:0]  e_widx;
      logic [1:0]  e_src;
      logic [31:0] e_addr, e_sdata, e_pval, e_tgt;
      logic [2:0]  e_br;
      string       tag;
      @(negedge clk);
      instr  = {6'(op), 5'(a), 5'(b), d};
      ra_val = nextrnd();
      rb_val = (op % 3 == 0) ? 32'hFFFF_FFF0 : nextrnd();
      rc_val = nextrnd();
      #2;
      sx = {{16{d[15]}}, d};
      zx = {16'h0, d};
      e_ill = (op >= 26 && op <= 31) || op >= 54;
      e_trap = (op == 51);
      e_imm = (op >= 10 && op <= 25);
      e_reg = (op >= 32 && op <= 47);
      e_wr = 0; e_ptr = 0; e_rd = 0; e_wrm = 0; e_split = 0;
      e_widx = 5'(a); e_src = 2'd0; e_addr = '0; e_sdata = ra_val; e_pval = '0;
      e_br = 3'd0; e_tgt = zx;
      tag = "R10";
      case (op)
         1:  begin tag = "R2"; e_wr = 1; e_src = 1; e_rd = 1; e_addr = zx; end
         3:  begin tag = "R2"; e_wrm = 1; e_addr = zx; end
         2:  begin tag = "R3"; e_wr = 1; e_src = 1; e_rd = 1; e_addr = sx + rb_val; end
         4:  begin tag = "R3"; e_wrm = 1; e_addr = sx + rb_val; end
         48: begin tag = "R4"; e_wr = 1; e_src = 1; e_rd = 1; e_addr = rb_val + rc_val; end
         49: begin tag = "R4"; e_wrm = 1; e_addr = rb_val + rc_val; end
         52: begin tag = "R5"; e_ptr = 1; e_pval = ra_val + 1; e_wrm = 1; e_addr = ra_val + 1; e_sdata = rb_val; e_split = 1; end
         53: begin tag = "R6"; e_wr = 1; e_widx = 5'(b); e_src = 1; e_rd = 1; e_addr = ra_val; e_ptr = 1; e_pval = ra_val - 1; e_split = 1; end
         6:  begin tag = "R9"; e_br = 1; end
         7:  begin tag = "R9"; e_br = 2; e_wr = 1; e_src = 2; end
         8:  begin tag = "R9"; e_br = 3; end
         9:  begin tag = "R9"; e_br = 4; end
         50: begin tag = "R9"; e_br = 5; e_tgt = ra_val; end
         default: begin
            if (e_imm) tag = "R7";
            else if (e_reg) tag = "R8";
            else if (e_ill) tag = "R11";
            if (e_imm || e_reg) e_wr = 1;
         end
      endcase
      // R1: field positions
      chk("R1", "ra_idx", 32'(ra_idx), 32'(a));
      chk("R1", "rb_idx", 32'(rb_idx), 32'(b));
      chk("R1", "rc_idx", 32'(rc_idx), 32'(d[4:0]));
      chk(tag, "illegal", 32'(illegal), 32'(e_ill));
      chk(tag, "trap", 32'(trap), 32'(e_trap));
      chk(tag, "split_req", 32'(split_req), 32'(e_split));
      chk(tag, "mem_rd", 32'(mem_rd), 32'(e_rd));
      chk(tag, "mem_wr", 32'(mem_wr), 32'(e_wrm));
      chk("R13", "strobe_excl", 32'(mem_rd & mem_wr), 32'd0);
      chk(tag, "br_kind", 32'(br_kind), 32'(e_br));
      if (e_br != 0) chk(tag, "br_target", br_target, e_tgt);
      chk(tag, "alu_valid", 32'(alu_valid), 32'(e_imm | e_reg));
      if (e_imm) begin
         chk("R7", "alu_op", 32'(alu_op), 32'(op - 10));
         chk("R7", "opb", opb, sx);
      end
      if (e_reg) begin
         chk("R8", "alu_op", 32'(alu_op), 32'(op - 32));
         chk("R8", "opb", opb, rc_val);
      end
      if (e_rd || e_wrm) chk(tag, "mem_addr", mem_addr, e_addr);
      if (e_wrm) chk(tag, "store_data", store_data, e_sdata);
      // R12: index zero masks the enable
      chk((e_wr && e_widx == 0) ? "R12" : tag, "wr_en", 32'(wr_en), 32'(e_wr && e_widx != 0));
      if (e_wr && e_widx != 0) begin
         chk(tag, "wr_idx", 32'(wr_idx), 32'(e_widx));
         chk(tag, "wr_src", 32'(wr_src), 32'(e_src));
      end
      chk((e_ptr && a == 0) ? "R12" : tag, "ptr_wr_en", 32'(ptr_wr_en), 32'(e_ptr && a != 0));
      if (e_ptr) begin
         chk(tag, "ptr_value", ptr_value, e_pval);
         if (a != 0) chk(tag, "ptr_wr_idx", 32'(ptr_wr_idx), 32'(a));
      end
   endtask

   initial begin
      int r1s[3];
      int r2s[2];
      logic [15:0] ds[3];
      r1s = '{0, 7, 31};
      r2s = '{0, 13};
      ds  = '{16'h0005, 16'hFFF3, 16'h8003};
      // idle word: all-zero instruction is a no-op (R10)
      run_vec(0, 0, 0, 16'h0000);
      for (int op = 0; op < 64; op++) begin
         for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 2; j++) begin
               for (int k = 0; k < 3; k++) begin
                  run_vec(op, r1s[i], r2s[j], ds[k]);
               end
            end
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule